// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one frame at a time, whether a received Ethernet frame is kept or dropped. For each frame it is given the 48-bit destination address, a CRC-32 computed elsewhere over that address, the frame length in bytes and the error flags from the receive path. It compares the destination with the station's own address and looks up a 64-bin multicast hash table. It then applies the receive configuration: promiscuous unicast, broadcast acceptance, multicast acceptance, runt acceptance and keeping frames with errors.

The decision comes out one clock after the frame is presented. It is a pulse on exactly one of accept or reject, together with a group flag for the receive status byte. Two hash bins have a special role when auto-transmit-disable is enabled. A clean multicast frame that lands in bin 62 switches the local transmitter off. One that lands in bin 63 switches it back on. A level output reports whether the transmitter is enabled, and a one-cycle pulse marks each switch.

The station address, hash table and configuration bits are static inputs that the surrounding receive logic holds.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, dec_valid, dec_accept, dec_reject, dec_group, tx_disable_evt and tx_enable_evt are 0 and tx_enabled is 1.
- R2: A frame presented with frm_valid high at a rising edge produces dec_valid high in the following cycle, with exactly one of dec_accept and dec_reject high. With no frame presented, all three are low.
- R3: A unicast destination (bit 40 of frm_dest is 0; frm_dest[47:40] is the first byte on the wire) passes the address check only if cfg_promisc is 1 or frm_dest equals station_addr.
- R4: The all-ones destination passes the address check exactly when cfg_bcast_en is 1, whatever the hash table and cfg_mcast_en hold.
- R5: Any other multicast destination passes the address check only when cfg_mcast_en is 1 and hash_table bit n is 1. Here n = frm_dest_crc[31:26]: table byte n[5:3], bit n[2:0] within that byte, which is hash_table[8*n[5:3] + n[2:0]].
- R6: A frame with frm_len below 64 is rejected unless cfg_runt_en is 1.
- R7: A frame with frm_crc_err or frm_align_err set is rejected unless cfg_save_err is 1.
- R8: With dec_valid, dec_group is 1 for a multicast or broadcast destination and 0 for a unicast one.
- R9: With cfg_atd_en set, a non-broadcast multicast frame with no CRC or alignment error whose hash bin is 62 pulses tx_disable_evt and clears tx_enabled. If its bin is 63, it pulses tx_enable_evt and sets tx_enabled. This happens in the decision cycle, whatever the acceptance outcome. With cfg_atd_en clear, neither event occurs.
- R10: tx_enabled changes only in a cycle that carries one of the two events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_promisc | input | 1 | Accept every unicast destination |
| cfg_bcast_en | input | 1 | Accept the broadcast destination |
| cfg_mcast_en | input | 1 | Accept multicast destinations whose hash bin is set |
| cfg_runt_en | input | 1 | Keep frames shorter than 64 bytes |
| cfg_save_err | input | 1 | Keep frames with CRC or alignment errors |
| cfg_atd_en | input | 1 | Enable remote transmitter control via bins 62/63 |
| station_addr | input | 48 | Own station address, first byte in [47:40] |
| hash_table | input | 64 | Multicast hash bins, byte k in [8k+7:8k] |
| frm_valid | input | 1 | Frame fields below are valid this cycle |
| frm_dest | input | 48 | Destination address, first byte in [47:40] |
| frm_dest_crc | input | 32 | CRC-32 of the destination address |
| frm_len | input | 16 | Frame length in bytes |
| frm_crc_err | input | 1 | Frame had a CRC error |
| frm_align_err | input | 1 | Frame had an alignment error |
| dec_valid | output | 1 | Decision present this cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_reject | output | 1 | Frame rejected |
| dec_group | output | 1 | Status flag: 1 group address, 0 physical address |
| tx_disable_evt | output | 1 | Transmitter switched off this cycle |
| tx_enable_evt | output | 1 | Transmitter switched on this cycle |
| tx_enabled | output | 1 | Current transmitter enable state |

## Verification
On every cycle the assertions check the following. A frame yields exactly one outcome in the next cycle. No accepted frame breaks the runt, error or unicast-address rules. The group flag follows the destination's multicast bit. The transmitter state moves only with its event pulses and in the direction each pulse names.

Some behaviour only the bench's sweeps can show. One is that the right hash bit is chosen for every one of the 64 bins. Another is that broadcast ignores the table. A third is that the length and error boundaries sit exactly at 63/64 bytes and at each error flag. The bench also shows that the bin 62/63 controls act only when enabled and on clean frames.

// File: rtl/rxf_pkg.sv
// Shared types for the receive address filter.
// Assumes: one destination class per frame, decided combinationally.
package rxf_pkg;
    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_MULTICAST = 2'd1,
        DST_BROADCAST = 2'd2
    } dst_kind_e;
endpackage

// File: rtl/rxf_dest_class.sv
// Classifies a destination address and applies the address-based acceptance
// rules (station match, promiscuous, broadcast, multicast hash).
// Assumes: the first byte on the wire sits in the top byte of dest; the
// CRC of the destination is supplied, and its top bits form the hash bin.
module rxf_dest_class #(
    parameter int ADDR_W    = 48,
    parameter int CRC_W     = 32,
    parameter int HASH_BINS = 64,
    localparam int NBYTES   = ADDR_W / 8,
    localparam int IDX_W    = $clog2(HASH_BINS)
) (
    input  logic [ADDR_W-1:0]    dest,
    input  logic [CRC_W-1:0]     dest_crc,
    input  logic [ADDR_W-1:0]    station,
    input  logic [HASH_BINS-1:0] table_bits,
    input  logic                 promisc,
    input  logic                 bcast_en,
    input  logic                 mcast_en,
    output rxf_pkg::dst_kind_e   kind,
    output logic [IDX_W-1:0]     bin_idx,
    output logic                 addr_ok
);
    import rxf_pkg::*;

    localparam int GRP_BIT = ADDR_W - 8;

    logic [NBYTES-1:0] byte_eq;
    logic              station_hit;
    logic              hash_hit;

    // Per-byte comparison against the station address.
    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_byte_cmp
            assign byte_eq[b] = (dest[8*b +: 8] == station[8*b +: 8]);
        end
    endgenerate

    assign station_hit = &byte_eq;
    assign bin_idx     = dest_crc[CRC_W-1 -: IDX_W];
    assign hash_hit    = table_bits[bin_idx];

    // Destination class: broadcast is recognised ahead of the hash path.
    always_comb begin
        if (&dest)              kind = DST_BROADCAST;
        else if (dest[GRP_BIT]) kind = DST_MULTICAST;
        else                    kind = DST_UNICAST;
    end

    // Address-based acceptance for each class.
    always_comb begin
        unique case (kind)
            DST_BROADCAST: addr_ok = bcast_en;
            DST_MULTICAST: addr_ok = mcast_en & hash_hit;
            default:       addr_ok = promisc | station_hit;
        endcase
    end
endmodule

// File: rtl/rxf_frame_check.sv
// Applies the length and error qualifiers to a frame.
// Assumes: the length counts the whole frame in bytes; error flags are final.
module rxf_frame_check #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic [LEN_W-1:0] len,
    input  logic             crc_err,
    input  logic             align_err,
    input  logic             runt_en,
    input  logic             save_err,
    output logic             clean,
    output logic             qual_ok
);
    logic is_runt;

    // Short-frame and error screening.
    always_comb begin
        is_runt = (len < LEN_W'(MIN_LEN));
        clean   = ~(crc_err | align_err);
        qual_ok = (~is_runt | runt_en) & (clean | save_err);
    end
endmodule

// File: rtl/rxf_txgate.sv
// Holds the transmitter enable state driven remotely through two reserved
// multicast hash bins when auto-transmit-disable is on.
// Assumes: frm_valid is a single-cycle strobe; only clean frames count.
module rxf_txgate #(
    parameter int HASH_BINS = 64,
    localparam int IDX_W    = $clog2(HASH_BINS),
    localparam int BIN_OFF  = HASH_BINS - 2,
    localparam int BIN_ON   = HASH_BINS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    input  logic               atd_en,
    input  rxf_pkg::dst_kind_e kind,
    input  logic               clean,
    input  logic [IDX_W-1:0]   bin_idx,
    output logic               dis_evt,
    output logic               ena_evt,
    output logic               tx_en
);
    import rxf_pkg::*;

    logic ctl_frame;

    assign ctl_frame = frm_valid & atd_en & clean & (kind == DST_MULTICAST);

    // Register the event pulses and the enable state together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_evt <= 1'b0;
            ena_evt <= 1'b0;
            tx_en   <= 1'b1;
        end else begin
            dis_evt <= ctl_frame & (bin_idx == IDX_W'(BIN_OFF));
            ena_evt <= ctl_frame & (bin_idx == IDX_W'(BIN_ON));
            if (ctl_frame && bin_idx == IDX_W'(BIN_OFF))     tx_en <= 1'b0;
            else if (ctl_frame && bin_idx == IDX_W'(BIN_ON)) tx_en <= 1'b1;
        end
    end

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dis_evt && ena_evt)); // R9
    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_evt |-> !tx_en); // R9
    AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ena_evt |-> tx_en); // R9
    AST_EVT_NEEDS_ATD: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_evt || ena_evt) |-> $past(atd_en) && $past(frm_valid)); // R9
    AST_TXEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_evt && !ena_evt) |-> tx_en == $past(tx_en)); // R10
endmodule

// File: rtl/rx_addr_filter.sv
// Receive address filter top: combines the address decision and the frame
// qualifiers into one registered accept/reject outcome per frame, with the
// group status flag and the remote transmitter control.
// Assumes: frame fields are valid only in the cycle frm_valid is high and
// configuration inputs are held steady by the surrounding logic.
module rx_addr_filter #(
    parameter int ADDR_W    = 48,
    parameter int CRC_W     = 32,
    parameter int HASH_BINS = 64,
    parameter int LEN_W     = 16,
    parameter int MIN_LEN   = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_promisc,
    input  logic                 cfg_bcast_en,
    input  logic                 cfg_mcast_en,
    input  logic                 cfg_runt_en,
    input  logic                 cfg_save_err,
    input  logic                 cfg_atd_en,
    input  logic [ADDR_W-1:0]    station_addr,
    input  logic [HASH_BINS-1:0] hash_table,
    input  logic                 frm_valid,
    input  logic [ADDR_W-1:0]    frm_dest,
    input  logic [CRC_W-1:0]     frm_dest_crc,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic                 frm_crc_err,
    input  logic                 frm_align_err,
    output logic                 dec_valid,
    output logic                 dec_accept,
    output logic                 dec_reject,
    output logic                 dec_group,
    output logic                 tx_disable_evt,
    output logic                 tx_enable_evt,
    output logic                 tx_enabled
);
    import rxf_pkg::*;

    localparam int IDX_W   = $clog2(HASH_BINS);
    localparam int GRP_BIT = ADDR_W - 8;

    dst_kind_e        kind;
    logic [IDX_W-1:0] bin_idx;
    logic             addr_ok;
    logic             qual_ok;
    logic             clean;
    logic             keep;

    rxf_dest_class #(
        .ADDR_W    (ADDR_W),
        .CRC_W     (CRC_W),
        .HASH_BINS (HASH_BINS)
    ) u_dest_class (
        .dest       (frm_dest),
        .dest_crc   (frm_dest_crc),
        .station    (station_addr),
        .table_bits (hash_table),
        .promisc    (cfg_promisc),
        .bcast_en   (cfg_bcast_en),
        .mcast_en   (cfg_mcast_en),
        .kind       (kind),
        .bin_idx    (bin_idx),
        .addr_ok    (addr_ok)
    );

    rxf_frame_check #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_frame_check (
        .len       (frm_len),
        .crc_err   (frm_crc_err),
        .align_err (frm_align_err),
        .runt_en   (cfg_runt_en),
        .save_err  (cfg_save_err),
        .clean     (clean),
        .qual_ok   (qual_ok)
    );

    rxf_txgate #(
        .HASH_BINS (HASH_BINS)
    ) u_txgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .atd_en    (cfg_atd_en),
        .kind      (kind),
        .clean     (clean),
        .bin_idx   (bin_idx),
        .dis_evt   (tx_disable_evt),
        .ena_evt   (tx_enable_evt),
        .tx_en     (tx_enabled)
    );

    assign keep = addr_ok & qual_ok;

    // Register the per-frame outcome and the status group flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reject <= 1'b0;
            dec_group  <= 1'b0;
        end else begin
            dec_valid  <= frm_valid;
            dec_accept <= frm_valid & keep;
            dec_reject <= frm_valid & ~keep;
            dec_group  <= frm_valid & (kind != DST_UNICAST);
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept != dec_reject)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept && !dec_reject && !dec_group); // R2
    AST_FRAME_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_valid); // R2
    AST_UNICAST_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_accept && !dec_group) |->
            ($past(cfg_promisc) || $past(frm_dest) == $past(station_addr))); // R3
    AST_RUNT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> ($past(frm_len) >= LEN_W'(MIN_LEN) || $past(cfg_runt_en))); // R6
    AST_ERROR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> (!($past(frm_crc_err) || $past(frm_align_err)) || $past(cfg_save_err))); // R7
    AST_GROUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_group == $past(frm_dest[GRP_BIT])); // R8
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_promisc = 0, cfg_bcast_en = 0, cfg_mcast_en = 0;
    logic        cfg_runt_en = 0, cfg_save_err = 0, cfg_atd_en = 0;
    logic [47:0] station_addr = 48'h02_1A_3C_55_7E_91;
    logic [63:0] hash_table   = 64'hA5C3_0F96_3C5A_E718;
    logic        frm_valid = 0;
    logic [47:0] frm_dest = '0;
    logic [31:0] frm_dest_crc = '0;
    logic [15:0] frm_len = 16'd100;
    logic        frm_crc_err = 0, frm_align_err = 0;
    logic        dec_valid, dec_accept, dec_reject, dec_group;
    logic        tx_disable_evt, tx_enable_evt, tx_enabled;

    int  errors = 0;
    int  checks = 0;
    bit  exp_tx = 1'b1;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
        .cfg_mcast_en(cfg_mcast_en), .cfg_runt_en(cfg_runt_en),
        .cfg_save_err(cfg_save_err), .cfg_atd_en(cfg_atd_en),
        .station_addr(station_addr), .hash_table(hash_table),
        .frm_valid(frm_valid), .frm_dest(frm_dest), .frm_dest_crc(frm_dest_crc),
        .frm_len(frm_len), .frm_crc_err(frm_crc_err), .frm_align_err(frm_align_err),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reject(dec_reject),
        .dec_group(dec_group), .tx_disable_evt(tx_disable_evt),
        .tx_enable_evt(tx_enable_evt), .tx_enabled(tx_enabled)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one frame, then check every output in the decision cycle.
    task automatic send(input logic [47:0] d, input logic [5:0] bin,
                        input logic [15:0] len, input bit ce, input bit ae);
        bit grp, bc, clean, addr_ok, qual_ok, dis, ena;
        string atag;
        @(negedge clk);
        frm_dest      = d;
        frm_dest_crc  = {bin, 26'h2A5_1C3};
        frm_len       = len;
        frm_crc_err   = ce;
        frm_align_err = ae;
        frm_valid     = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        bc    = (d == 48'hFFFF_FFFF_FFFF);
        grp   = d[40];
        clean = !(ce || ae);
        if (bc) begin
            addr_ok = cfg_bcast_en; atag = "R4";
        end else if (grp) begin
            addr_ok = cfg_mcast_en && hash_table[{bin[5:3], bin[2:0]}]; atag = "R5";
        end else begin
            addr_ok = cfg_promisc || (d == station_addr); atag = "R3";
        end
        qual_ok = (len >= 16'd64 || cfg_runt_en) && (clean || cfg_save_err);
        if (len < 16'd64) atag = {atag, "/R6"};
        if (!clean)       atag = {atag, "/R7"};
        dis = cfg_atd_en && grp && !bc && clean && bin == 6'd62;
        ena = cfg_atd_en && grp && !bc && clean && bin == 6'd63;
        if (dis) exp_tx = 1'b0;
        if (ena) exp_tx = 1'b1;
        chk("R2 dec_valid", dec_valid, 1);
        chk({atag, " accept"}, dec_accept, addr_ok && qual_ok);
        chk({atag, " reject"}, dec_reject, !(addr_ok && qual_ok));
        chk("R8 group", dec_group, grp);
        chk("R9 disable event", tx_disable_evt, dis);
        chk("R9 enable event", tx_enable_evt, ena);
        chk("R10 tx_enabled", tx_enabled, exp_tx);
    endtask

    task automatic set_cfg(input logic [5:0] c);
        {cfg_atd_en, cfg_save_err, cfg_runt_en, cfg_mcast_en, cfg_bcast_en, cfg_promisc} = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset.
        chk("R1 valid", dec_valid, 0);
        chk("R1 accept", dec_accept, 0);
        chk("R1 reject", dec_reject, 0);
        chk("R1 events", {tx_disable_evt, tx_enable_evt}, 0);
        chk("R1 tx_enabled", tx_enabled, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {dec_valid, dec_accept, dec_reject, dec_group}, 0);
        // R2: idle cycle gives no decision.
        @(negedge clk);
        chk("R2 idle", {dec_valid, dec_accept, dec_reject}, 0);

        // Configuration sweep over four destination kinds.
        for (int c = 0; c < 64; c++) begin
            set_cfg(6'(c));
            send(station_addr, 6'(c), 16'd80, 0, 0);
            send(48'h00_1B_22_33_44_55 ^ 48'(c), 6'(c * 5), 16'd80, 0, 0);
            send(48'hFFFF_FFFF_FFFF, 6'(c * 3), 16'd80, 0, 0);
            send(48'h01_00_5E_00_00_00 | 48'(c), 6'((c * 7) % 64), 16'd80, 0, 0);
        end

        // R5: every hash bin with multicast acceptance on and off (ATD on).
        for (int m = 0; m < 2; m++) begin
            set_cfg({1'b1, 2'b00, 1'(m), 2'b00});
            for (int b = 0; b < 64; b++)
                send(48'h03_11_22_33_44_00 | 48'(b), 6'(b), 16'd128, 0, 0);
        end

        // R4: broadcast ignores an empty hash table and multicast disable.
        hash_table = '0;
        set_cfg(6'b000010);
        send(48'hFFFF_FFFF_FFFF, 6'd62, 16'd64, 0, 0);
        hash_table = 64'hA5C3_0F96_3C5A_E718;

        // R6 / R7: length boundary and error flags.
        for (int k = 0; k < 4; k++) begin
            set_cfg({2'b00, 1'(k >> 1), 2'b00, 1'b1});
            for (int l = 60; l < 68; l++) begin
                send(station_addr, 6'd0, 16'(l), 0, 0);
                send(station_addr, 6'd0, 16'(l), 1, 0);
                send(station_addr, 6'd0, 16'(l), 0, 1);
                cfg_save_err = 1'(k);
                send(station_addr, 6'd0, 16'(l), 1, 1);
                cfg_save_err = 1'b0;
            end
        end

        // R9: errored frames in bins 62/63 leave the transmitter alone.
        set_cfg(6'b111111);
        send(48'h01_00_00_00_00_62, 6'd62, 16'd80, 1, 0);
        send(48'h01_00_00_00_00_62, 6'd62, 16'd80, 0, 0);
        send(48'h01_00_00_00_00_63, 6'd63, 16'd80, 0, 1);
        send(48'h01_00_00_00_00_63, 6'd63, 16'd80, 0, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule